// File: doc/BRIEF.md
# Syndrome-Addressed Error Log

This block keeps a one-bit flag for each possible combination of error details seen by a memory read path. When the correction logic reports a nonzero syndrome during a read or during the first phase of a read-modify-write, the block sets a flag. The position of that flag is built from the syndrome, the three low address bits, the bank-select bit and the most significant address bit. The flag itself says only that an error happened. Which error it was is recorded in where the flag sits.

A maintenance port can read single flags and can overwrite them, usually with zero to clear an entry. Maintenance access is accepted only while the memory controller signals a refresh window, so diagnostics never lengthen a normal memory cycle. Reads on this port return data on the clock edge after the request.

Top module: `synd_err_log`

## Requirements
- R1: While reset is low, every flag clears to 0 and `maintRvalid` and `maintRdata` go to 0.
- R2: A logged error sets the flag at index `{syndrome[4:0], addrLow[2:0], bankBit, addrMsb}`, where `syndrome` forms bits 9..5 and `addrMsb` forms bit 0.
- R3: Logging takes place only when `cycleKind` is 2'b01 (read) or 2'b11 (read-modify-write first phase). Kinds 2'b00 (idle/refresh) and 2'b10 (write) never set a flag.
- R4: No flag is set when `errValid` is low, whatever the value of `cycleKind`.
- R5: A maintenance request made while `refreshWin` is low is ignored: writes change no flag and reads raise no `maintRvalid`.
- R6: An accepted maintenance read (`maintReq`=1, `maintWe`=0, `refreshWin`=1) raises `maintRvalid` for exactly one cycle after the request edge. In that cycle `maintRdata` holds the flag at `maintAddr`.
- R7: An accepted maintenance write (`maintWe`=1) stores `maintWdata` at `maintAddr`. Writing 0 clears a flag.
- R8: A maintenance request in the same cycle as a loggable error is dropped. The error is logged, the maintenance write does not happen, and a maintenance read returns no `maintRvalid`.
- R9: Logging an error sets only its own flag. All other flags keep their values.
- R10: `maintRdata` keeps its value in every cycle that follows no accepted maintenance read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | Read path reports a detected error this cycle |
| cycleKind | input | 2 | Memory cycle type: 00 idle, 01 read, 10 write, 11 RMW first phase |
| syndrome | input | 5 | Error syndrome of the failing word |
| addrLow | input | 3 | Low address bits of the failing word |
| bankBit | input | 1 | Bank-select bit of the failing word |
| addrMsb | input | 1 | Most significant address bit of the failing word |
| refreshWin | input | 1 | Refresh window active; maintenance access allowed |
| maintReq | input | 1 | Maintenance access request |
| maintWe | input | 1 | Maintenance write (1) or read (0) |
| maintAddr | input | 10 | Maintenance flag index |
| maintWdata | input | 1 | Maintenance write value |
| maintRdata | output | 1 | Maintenance read value |
| maintRvalid | output | 1 | Maintenance read value is valid this cycle |

## Verification
A logged error changes the array at the request edge. It can only be seen through a later maintenance read, whose flag and `maintRvalid` show up one edge after that read is requested. The bench drives every stimulus on the falling edge and samples at the next falling edge, just after the edge that registers the result. It also checks that `maintRvalid` has dropped again one cycle later. Address order, cycle-kind gating and arbitration are checked by scanning the whole array after isolated events, so a misplaced or extra flag anywhere is reported.

// File: rtl/synd_log_pkg.sv
package synd_log_pkg;

  // memory cycle kinds presented alongside an error report
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_RMW1  = 2'b11
  } cycKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic logSet;   // set the flag at the composed error index
    logic maintWr;  // store maintenance data
    logic maintRd;  // capture a flag for the maintenance port
  } logStrobes_t;

  function automatic logic loggableKind(input cycKind_e kind);
    return (kind == CYC_READ) || (kind == CYC_RMW1);
  endfunction

endpackage

// File: rtl/synd_log_ctrl.sv
module synd_log_ctrl
  import synd_log_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        errValid,
  input  logic [1:0]  cycleKind,
  input  logic        refreshWin,
  input  logic        maintReq,
  input  logic        maintWe,
  output logStrobes_t strobes,
  output logic        maintRvalid
);

  cycKind_e kindNow;
  logic     logHit;
  logic     maintGrant;

  assign kindNow = cycKind_e'(cycleKind);

  // error logging wins over maintenance in the same cycle
  always_comb begin
    logHit     = errValid && loggableKind(kindNow);
    maintGrant = maintReq && refreshWin && !logHit;
    strobes.logSet  = logHit;
    strobes.maintWr = maintGrant && maintWe;
    strobes.maintRd = maintGrant && !maintWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maintRvalid <= 1'b0;
    else       maintRvalid <= strobes.maintRd;
  end

endmodule

// File: rtl/synd_log_dp.sv
module synd_log_dp
  import synd_log_pkg::*;
#(
  parameter int SYND_W = 5,
  parameter int LOWA_W = 3,
  localparam int ADDR_W = SYND_W + LOWA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobes_t       strobes,
  input  logic [SYND_W-1:0] syndrome,
  input  logic [LOWA_W-1:0] addrLow,
  input  logic              bankBit,
  input  logic              addrMsb,
  input  logic [ADDR_W-1:0] maintAddr,
  input  logic              maintWdata,
  output logic              maintRdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] logAddr;
  logic [DEPTH-1:0]  flags;

  // syndrome in the top bits, address MSB in bit 0
  assign logAddr = {syndrome, addrLow, bankBit, addrMsb};

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic hitLog;
    logic hitMaint;
    assign hitLog   = strobes.logSet  && (logAddr   == ADDR_W'(gi));
    assign hitMaint = strobes.maintWr && (maintAddr == ADDR_W'(gi));
    always_ff @(posedge clk) begin
      if (!rstN)         flags[gi] <= 1'b0;
      else if (hitLog)   flags[gi] <= 1'b1;
      else if (hitMaint) flags[gi] <= maintWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                maintRdata <= 1'b0;
    else if (strobes.maintRd) maintRdata <= flags[maintAddr];
  end

endmodule

// File: rtl/synd_err_log.sv
module synd_err_log
  import synd_log_pkg::*;
#(
  parameter int SYND_W = 5,
  parameter int LOWA_W = 3,
  localparam int ADDR_W = SYND_W + LOWA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errValid,
  input  logic [1:0]        cycleKind,
  input  logic [SYND_W-1:0] syndrome,
  input  logic [LOWA_W-1:0] addrLow,
  input  logic              bankBit,
  input  logic              addrMsb,
  input  logic              refreshWin,
  input  logic              maintReq,
  input  logic              maintWe,
  input  logic [ADDR_W-1:0] maintAddr,
  input  logic              maintWdata,
  output logic              maintRdata,
  output logic              maintRvalid
);

  logStrobes_t strobes;

  synd_log_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .errValid   (errValid),
    .cycleKind  (cycleKind),
    .refreshWin (refreshWin),
    .maintReq   (maintReq),
    .maintWe    (maintWe),
    .strobes    (strobes),
    .maintRvalid(maintRvalid)
  );

  synd_log_dp #(
    .SYND_W(SYND_W),
    .LOWA_W(LOWA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .syndrome  (syndrome),
    .addrLow   (addrLow),
    .bankBit   (bankBit),
    .addrMsb   (addrMsb),
    .maintAddr (maintAddr),
    .maintWdata(maintWdata),
    .maintRdata(maintRdata)
  );

endmodule

// File: rtl/synd_err_log_chk.sv
module synd_err_log_chk (
  input logic       clk,
  input logic       rstN,
  input logic       errValid,
  input logic [1:0] cycleKind,
  input logic       refreshWin,
  input logic       maintReq,
  input logic       maintWe,
  input logic       maintRdata,
  input logic       maintRvalid
);

  logic logCond;
  logic readAsk;
  assign logCond = errValid && (cycleKind == 2'b01 || cycleKind == 2'b11);
  assign readAsk = maintReq && refreshWin && !maintWe;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!maintRvalid && !maintRdata)); // R1

  AST_NO_READ_OUTSIDE_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    (maintReq && !refreshWin) |=> !maintRvalid); // R5

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    (readAsk && !logCond) |=> maintRvalid); // R6

  AST_RVALID_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    maintRvalid |-> $past(readAsk && !logCond)); // R6

  AST_ERROR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (maintReq && logCond) |=> !maintRvalid); // R8

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !readAsk |=> $stable(maintRdata)); // R10

endmodule

bind synd_err_log synd_err_log_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .errValid   (errValid),
  .cycleKind  (cycleKind),
  .refreshWin (refreshWin),
  .maintReq   (maintReq),
  .maintWe    (maintWe),
  .maintRdata (maintRdata),
  .maintRvalid(maintRvalid)
);

// File: tb/sim_synd_err_log.sv
`timescale 1ns/1ps
module sim_synd_err_log;

  localparam int DEPTH = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       errValid = 1'b0;
  logic [1:0] cycleKind = 2'b00;
  logic [4:0] syndrome = '0;
  logic [2:0] addrLow = '0;
  logic       bankBit = 1'b0;
  logic       addrMsb = 1'b0;
  logic       refreshWin = 1'b0;
  logic       maintReq = 1'b0;
  logic       maintWe = 1'b0;
  logic [9:0] maintAddr = '0;
  logic       maintWdata = 1'b0;
  logic       maintRdata;
  logic       maintRvalid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  synd_err_log u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setFields(input int idx);
    syndrome = 5'(idx / 32);
    addrLow  = 3'((idx / 4) % 8);
    bankBit  = 1'((idx / 2) % 2);
    addrMsb  = 1'(idx % 2);
  endtask

  task automatic logErr(input logic [1:0] kind, input int idx, input bit err);
    @(negedge clk);
    errValid = err; cycleKind = kind; setFields(idx);
    @(negedge clk);
    errValid = 1'b0; cycleKind = 2'b00;
  endtask

  task automatic mWrite(input int idx, input logic d, input bit refresh);
    @(negedge clk);
    maintReq = 1'b1; maintWe = 1'b1; maintAddr = 10'(idx);
    maintWdata = d; refreshWin = refresh;
    @(negedge clk);
    maintReq = 1'b0; maintWe = 1'b0; refreshWin = 1'b0;
  endtask

  task automatic mRead(input int idx, input bit refresh, output logic v, output logic d);
    @(negedge clk);
    maintReq = 1'b1; maintWe = 1'b0; maintAddr = 10'(idx); refreshWin = refresh;
    @(negedge clk);
    maintReq = 1'b0; refreshWin = 1'b0;
    v = maintRvalid; d = maintRdata;
  endtask

  // read every flag; expected is all ones when fill, else one at onlyIdx
  task automatic scan(input string req, input int onlyIdx, input bit fill);
    logic v, d;
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      mRead(i, 1'b1, v, d);
      if (v !== 1'b1 || d !== (fill ? 1'b1 : 1'(i == onlyIdx))) begin
        bad++;
        if (bad <= 4)
          $display("FAIL %s entry %0d actual=%0b/%0b expected=1/%0b",
                   req, i, v, d, fill ? 1'b1 : 1'(i == onlyIdx));
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic v, d;
    int singles [13] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 256, 512, 1023, 677};

    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", int'(maintRvalid), 0);
    check("R1 rdata in reset", int'(maintRdata), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rvalid after reset", int'(maintRvalid), 0);
    scan("R1 cleared array", -1, 1'b0);

    // R2 R9: one error at a time, location from field weights
    for (int k = 0; k < 13; k++) begin
      logErr((k % 2) ? 2'b11 : 2'b01, singles[k], 1'b1);
      scan("R2 R9 single flag", singles[k], 1'b0);
      mWrite(singles[k], 1'b0, 1'b1);
    end

    // R2 full sweep: every combination logs; then R7 clears all
    for (int i = 0; i < DEPTH; i++) logErr((i % 3 == 0) ? 2'b11 : 2'b01, i, 1'b1);
    scan("R2 all flags set", -1, 1'b1);
    for (int i = 0; i < DEPTH; i++) mWrite(i, 1'b0, 1'b1);
    scan("R7 cleared by writes", -1, 1'b0);

    // R7 write a one
    mWrite(300, 1'b1, 1'b1);
    mRead(300, 1'b1, v, d);
    check("R7 written one", int'(d), 1);
    // R6 valid for one cycle only
    check("R6 rvalid after read", int'(v), 1);
    @(negedge clk);
    check("R6 rvalid drops", int'(maintRvalid), 0);
    check("R10 rdata held", int'(maintRdata), 1);
    mWrite(300, 1'b0, 1'b1);

    // R3 R4: no logging from idle/write kinds or without errValid
    for (int i = 0; i < 16; i++) begin
      logErr(2'b10, i * 61, 1'b1);
      logErr(2'b00, i * 61 + 7, 1'b1);
      logErr(2'b01, i * 61 + 3, 1'b0);
      logErr(2'b11, i * 61 + 5, 1'b0);
    end
    scan("R3 R4 nothing logged", -1, 1'b0);

    // R5: gated maintenance
    mRead(40, 1'b1, v, d);
    check("R10 prior rdata", int'(d), 0);
    mWrite(40, 1'b1, 1'b0);
    mRead(40, 1'b0, v, d);
    check("R5 no rvalid outside refresh", int'(v), 0);
    mRead(40, 1'b1, v, d);
    check("R5 write outside refresh ignored", int'(d), 0);
    mWrite(41, 1'b1, 1'b1);
    mRead(41, 1'b1, v, d);
    check("R7 set entry 41", int'(d), 1);
    mRead(40, 1'b0, v, d);
    check("R10 rdata held on denied read", int'(d), 1);
    check("R5 denied read rvalid", int'(v), 0);
    mWrite(41, 1'b0, 1'b1);

    // R8: error wins over a maintenance write
    @(negedge clk);
    errValid = 1'b1; cycleKind = 2'b01; setFields(500);
    maintReq = 1'b1; maintWe = 1'b1; maintAddr = 10'd77; maintWdata = 1'b1; refreshWin = 1'b1;
    @(negedge clk);
    errValid = 1'b0; cycleKind = 2'b00; maintReq = 1'b0; maintWe = 1'b0; refreshWin = 1'b0;
    mRead(77, 1'b1, v, d);
    check("R8 dropped maint write", int'(d), 0);
    mRead(500, 1'b1, v, d);
    check("R8 error still logged", int'(d), 1);
    // R8: error wins over a maintenance read
    @(negedge clk);
    errValid = 1'b1; cycleKind = 2'b11; setFields(600);
    maintReq = 1'b1; maintWe = 1'b0; maintAddr = 10'd500; refreshWin = 1'b1;
    @(negedge clk);
    errValid = 1'b0; cycleKind = 2'b00; maintReq = 1'b0; refreshWin = 1'b0;
    check("R8 dropped maint read", int'(maintRvalid), 0);
    mRead(600, 1'b1, v, d);
    check("R8 RMW error logged", int'(d), 1);

    // R1: reset clears flags again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1 rdata after re-reset", int'(maintRdata), 0);
    mRead(600, 1'b1, v, d);
    check("R1 flag cleared by reset", int'(d), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule